// File: doc/BRIEF.md
# Console Keyboard and Display Register Unit

This block sits on a 16-bit CPU load/store bus and gives software four word registers for a character console: a status word and a data word for an incoming keyboard, and the same pair for an outgoing display. Software polls a status word until its top bit is set. It then reads a keystroke from the keyboard data word, or writes a character to the display data word.

On the keyboard side, a byte stream comes in on a valid/ready handshake. A byte is taken only on a cycle where `key_valid` and `key_ready` are both high. Once a byte is taken, `key_ready` stays low, and the source must hold or drop further bytes until software reads the keyboard data word. On the display side, each accepted write sends one byte to the sink as a single-cycle `disp_valid` pulse. The unit then reports the display busy until the sink pulses `disp_done`. The sink cannot stall the pulse itself; it applies back-pressure only by delaying `disp_done`.

Bus reads are registered. `bus_rdata` takes the addressed word on the clock edge that samples `bus_rd` and holds it until the next read.

Top module: `console_regs`

## Requirements
- R1: The register addresses are: keyboard status 16'hF400, keyboard data 16'hF401, display status 16'hF3FC, display data 16'hF3FF. A read presents its word on `bus_rdata` in the cycle after `bus_rd` is sampled.
- R2: A byte on `key_data` is captured when `key_valid` and `key_ready` are both high. A later read of keyboard data returns that byte in bits 7:0 and zeros in bits 15:8.
- R3: A keyboard status read returns the pending flag in bit 15 and zeros in bits 14:0.
- R4: While a keystroke is pending, `key_ready` is 0. Bytes offered in that time are dropped and the stored byte is unchanged.
- R5: A read of keyboard data clears the pending flag, and `key_ready` is 1 from the next cycle.
- R6: A display status read returns display-ready in bit 15 and zeros in bits 14:0.
- R7: A write to display data while display-ready is 1 raises `disp_valid` for exactly one cycle, starting the cycle after the write. It puts `bus_wdata[7:0]` on `disp_data` and clears display-ready.
- R8: Display-ready returns to 1 in the cycle after `disp_done` is sampled high while it is 0.
- R9: A write to display data while display-ready is 0 gives no pulse and leaves the stored display byte unchanged.
- R10: A read of display data returns the last accepted display byte in bits 7:0 and zeros in bits 15:8.
- R11: Writes to keyboard status, keyboard data and display status change no register.
- R12: A read of any other address returns zero and changes no state.
- R13: Synchronous reset clears both data bytes and the pending flag, and sets display-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Bus word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| key_valid | input | 1 | Keystroke offered |
| key_data | input | 8 | Keystroke byte |
| key_ready | output | 1 | Keystroke can be taken (low while one is pending) |
| disp_valid | output | 1 | One-cycle pulse carrying a display byte |
| disp_data | output | 8 | Display byte |
| disp_done | input | 1 | Sink finished with the last byte |

## Verification
The bench builds the unit with its default parameters: a 16-bit word, an 8-bit character and the four fixed addresses. With these values, the flag lands in bit 15 and the high byte of every data read must be zero. Those settings make the exact word values observable, including a byte of all ones that would expose any leak into bits 15:8. The fixed addresses also leave neighbouring unmapped addresses (16'hF402, 16'hF3FD) inside the decoded window, which checks that decoding matches the full address rather than a partial one.

// File: rtl/console_pkg.sv
package console_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA
  } reg_sel_e;

endpackage

// File: rtl/kbd_port.sv
module kbd_port #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_data,
  output logic              key_ready,
  input  logic              clr_pend,
  output logic              pend_q,
  output logic [CHAR_W-1:0] char_q
);

  logic accept;

  assign accept    = key_valid && !pend_q;
  assign key_ready = !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      char_q <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      char_q <= key_data;
    end else if (clr_pend) begin
      pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/disp_port.sv
module disp_port #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_char,
  input  logic [CHAR_W-1:0] wr_byte,
  input  logic              disp_done,
  output logic              ready_q,
  output logic              valid_q,
  output logic [CHAR_W-1:0] char_q
);

  logic take;

  assign take = wr_char && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= take;
      if (take) begin
        char_q  <= wr_byte;
        ready_q <= 1'b0;
      end else if (disp_done) begin
        ready_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/con_rd_mux.sv
module con_rd_mux
  import console_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  reg_sel_e          sel,
  input  logic              kbd_pend,
  input  logic [CHAR_W-1:0] kbd_char,
  input  logic              dsp_ready,
  input  logic [CHAR_W-1:0] dsp_char,
  output logic [WORD_W-1:0] word
);

  localparam int unsigned FLAG_BIT = WORD_W - 1;

  always_comb begin
    word = '0;
    unique case (sel)
      SEL_KSTAT: word[FLAG_BIT]   = kbd_pend;
      SEL_KDATA: word[CHAR_W-1:0] = kbd_char;
      SEL_DSTAT: word[FLAG_BIT]   = dsp_ready;
      SEL_DDATA: word[CHAR_W-1:0] = dsp_char;
      default:   word = '0;
    endcase
  end

endmodule

// File: rtl/console_regs.sv
module console_regs
  import console_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned CHAR_W     = 8,
  parameter logic [15:0] KSTAT_ADDR = 16'hF400,
  parameter logic [15:0] KDATA_ADDR = 16'hF401,
  parameter logic [15:0] DSTAT_ADDR = 16'hF3FC,
  parameter logic [15:0] DDATA_ADDR = 16'hF3FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_data,
  output logic              key_ready,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_data,
  input  logic              disp_done
);

  reg_sel_e          sel;
  logic              kbd_pend;
  logic [CHAR_W-1:0] kbd_char;
  logic              dsp_ready;
  logic [WORD_W-1:0] rd_word;

  always_comb begin
    unique case (bus_addr)
      KSTAT_ADDR: sel = SEL_KSTAT;
      KDATA_ADDR: sel = SEL_KDATA;
      DSTAT_ADDR: sel = SEL_DSTAT;
      DDATA_ADDR: sel = SEL_DDATA;
      default:    sel = SEL_NONE;
    endcase
  end

  kbd_port #(.CHAR_W(CHAR_W)) kbd_i (
    .clk       (clk),
    .rst       (rst),
    .key_valid (key_valid),
    .key_data  (key_data),
    .key_ready (key_ready),
    .clr_pend  (bus_rd && (sel == SEL_KDATA)),
    .pend_q    (kbd_pend),
    .char_q    (kbd_char)
  );

  disp_port #(.CHAR_W(CHAR_W)) dsp_i (
    .clk       (clk),
    .rst       (rst),
    .wr_char   (bus_wr && (sel == SEL_DDATA)),
    .wr_byte   (bus_wdata[CHAR_W-1:0]),
    .disp_done (disp_done),
    .ready_q   (dsp_ready),
    .valid_q   (disp_valid),
    .char_q    (disp_data)
  );

  con_rd_mux #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) mux_i (
    .sel       (sel),
    .kbd_pend  (kbd_pend),
    .kbd_char  (kbd_char),
    .dsp_ready (dsp_ready),
    .dsp_char  (disp_data),
    .word      (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/console_regs_chk.sv
module console_regs_chk #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned CHAR_W     = 8,
  parameter logic [15:0] KSTAT_ADDR = 16'hF400,
  parameter logic [15:0] KDATA_ADDR = 16'hF401,
  parameter logic [15:0] DSTAT_ADDR = 16'hF3FC,
  parameter logic [15:0] DDATA_ADDR = 16'hF3FF
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              key_valid,
  input logic              key_ready,
  input logic              disp_valid,
  input logic [CHAR_W-1:0] disp_data,
  input logic              disp_done,
  input logic              disp_rdy
);

  logic unmapped;
  logic ddata_wr;

  assign unmapped = (bus_addr != KSTAT_ADDR) && (bus_addr != KDATA_ADDR) &&
                    (bus_addr != DSTAT_ADDR) && (bus_addr != DDATA_ADDR);
  assign ddata_wr = bus_wr && (bus_addr == DDATA_ADDR);

  assert_kdata_high_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == KDATA_ADDR) |=> (bus_rdata[WORD_W-1:CHAR_W] == '0));

  assert_kstat_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == KSTAT_ADDR) |=> (bus_rdata[WORD_W-2:0] == '0));

  assert_key_lock_R4: assert property (@(posedge clk) disable iff (rst)
    (key_valid && key_ready) |=> !key_ready);

  assert_take_byte_R7: assert property (@(posedge clk) disable iff (rst)
    (ddata_wr && disp_rdy) |=> (disp_valid && disp_data == $past(bus_wdata[CHAR_W-1:0])));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> !disp_valid);

  assert_done_restores_R8: assert property (@(posedge clk) disable iff (rst)
    (disp_done && !disp_rdy) |=> disp_rdy);

  assert_busy_write_dropped_R9: assert property (@(posedge clk) disable iff (rst)
    (ddata_wr && !disp_rdy) |=> !disp_valid);

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unmapped) |=> (bus_rdata == '0));

endmodule

bind console_regs console_regs_chk #(
  .WORD_W(WORD_W), .CHAR_W(CHAR_W),
  .KSTAT_ADDR(KSTAT_ADDR), .KDATA_ADDR(KDATA_ADDR),
  .DSTAT_ADDR(DSTAT_ADDR), .DDATA_ADDR(DDATA_ADDR)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .key_valid  (key_valid),
  .key_ready  (key_ready),
  .disp_valid (disp_valid),
  .disp_data  (disp_data),
  .disp_done  (disp_done),
  .disp_rdy   (dsp_ready)
);

// File: tb/console_regs_tb_top.sv
module console_regs_tb_top;

  localparam logic [15:0] KS = 16'hF400;
  localparam logic [15:0] KD = 16'hF401;
  localparam logic [15:0] DS = 16'hF3FC;
  localparam logic [15:0] DD = 16'hF3FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        key_valid = 1'b0;
  logic [7:0]  key_data = '0;
  logic        key_ready;
  logic        disp_valid;
  logic [7:0]  disp_data;
  logic        disp_done = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_f = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t exp_q[$];
  logic     rd_seen = 1'b0;

  always #2 clk = ~clk;

  console_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_valid(key_valid), .key_data(key_data), .key_ready(key_ready),
    .disp_valid(disp_valid), .disp_data(disp_data), .disp_done(disp_done)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result with the scoreboard entry
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected read", 16'h0, 16'h1);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  always @(posedge clk) rd_seen <= bus_rd && !rst;

  task automatic bus_read(input logic [15:0] a, input logic [15:0] e, input string tag);
    rd_item_t it;
    it.exp = e;
    it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic key_send(input logic [7:0] b);
    key_data  = b;
    key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic sink_done();
    disp_done = 1'b1;
    @(negedge clk);
    disp_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_f) begin
      done_f = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R13 key_ready after reset", {15'd0, key_ready}, 16'd1);
    check("R13 disp_valid after reset", {15'd0, disp_valid}, 16'd0);
    bus_read(KS, 16'h0000, "R13 R3 kbd status after reset");
    bus_read(DS, 16'h8000, "R13 R6 display status after reset");
    bus_read(KD, 16'h0000, "R13 kbd data after reset");
    bus_read(DD, 16'h0000, "R13 display data after reset");

    // keyboard capture and lockout
    key_send(8'h41);
    check("R4 key_ready low while pending", {15'd0, key_ready}, 16'd0);
    bus_read(KS, 16'h8000, "R3 kbd status pending");
    key_send(8'h42);
    bus_read(KD, 16'h0041, "R2 R4 first byte kept");
    check("R5 key_ready after data read", {15'd0, key_ready}, 16'd1);
    bus_read(KS, 16'h0000, "R5 kbd status cleared");
    key_send(8'hFF);
    bus_read(KD, 16'h00FF, "R2 all-ones byte high zero");

    // ignored writes
    bus_write(KS, 16'hFFFF);
    bus_write(KD, 16'h1234);
    bus_write(DS, 16'h0000);
    bus_read(KS, 16'h0000, "R11 kbd status write ignored");
    bus_read(KD, 16'h00FF, "R11 kbd data write ignored");
    bus_read(DS, 16'h8000, "R11 display status write ignored");
    check("R11 no display pulse", {15'd0, disp_valid}, 16'd0);

    // display path
    bus_write(DD, 16'h1A5A);
    check("R7 pulse high", {15'd0, disp_valid}, 16'd1);
    check("R7 pulse byte", {8'd0, disp_data}, 16'h005A);
    bus_read(DS, 16'h0000, "R7 display busy");
    check("R7 pulse one cycle", {15'd0, disp_valid}, 16'd0);
    bus_write(DD, 16'h0033);
    check("R9 no pulse while busy", {15'd0, disp_valid}, 16'd0);
    bus_read(DD, 16'h005A, "R9 R10 display byte kept");
    sink_done();
    bus_read(DS, 16'h8000, "R8 ready after done");
    bus_write(DD, 16'h00C3);
    check("R7 second pulse", {15'd0, disp_valid}, 16'd1);
    sink_done();
    bus_read(DD, 16'h00C3, "R10 display readback");

    // unmapped addresses
    key_send(8'h62);
    bus_read(16'hF402, 16'h0000, "R12 unmapped F402");
    bus_read(16'hF3FD, 16'h0000, "R12 unmapped F3FD");
    check("R12 pending kept", {15'd0, key_ready}, 16'd0);
    bus_read(KS, 16'h8000, "R12 R1 status untouched");
    bus_read(KD, 16'h0062, "R1 data address");

    @(negedge clk);
    check("R1 scoreboard drained", 16'(exp_q.size()), 16'd0);
    finish_run();
  end

endmodule